// File: doc/BRIEF.md
# UART receive idle timeout

This block sits beside a UART receiver and flags when received data has been waiting too long without more characters arriving. Short messages that never reach the receive FIFO's fill threshold can then be moved out by software. The baud generator supplies a one-cycle tick per bit time. The receiver supplies a strobe for each completed character. The FIFO supplies its non-empty flag.

The idle time is measured in character periods, not clock cycles. A character period is 11 bit ticks, which covers start, data, parity and stop bits. A 7-bit threshold sets how many idle character periods raise the interrupt. A threshold of zero switches the function off. Values above 126 count as 126. The interrupt is sticky. Once it has fired, it can only fire again after a further character has been received.

Top module: `uart_rx_idle_timer`

## Requirements
- R1: After reset, `timeout_irq` is 0. Bit ticks with a non-empty FIFO but no received character since reset do not raise it.
- R2: Take the first clock edge that samples the (11·`thresh`)-th `bit_tick` after the last `byte_rx`, with `fifo_nonempty` high and `thresh` in 1..126. `timeout_irq` is 0 after that edge and 1 after the next clock edge.
- R3: Each `byte_rx` pulse restarts the idle count from zero.
- R4: While `fifo_nonempty` is 0, the idle count is held at zero and `timeout_irq` is not set. Counting starts from zero again when the FIFO becomes non-empty.
- R5: With `thresh` equal to 0, `timeout_irq` is never set.
- R6: A `thresh` value of 127 behaves exactly as 126: the interrupt follows the 1386th idle bit tick.
- R7: Once set, `timeout_irq` stays 1 until `irq_clear` is sampled high. It is 0 after that edge unless a new timeout fires in the same cycle.
- R8: After a timeout has fired, further idle bit ticks do not set `timeout_irq` again until another `byte_rx` is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud generator |
| byte_rx | input | 1 | One-cycle pulse per received character |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one byte |
| thresh | input | 7 | Idle threshold in character periods; 0 disables, above 126 clamps |
| irq_clear | input | 1 | Clears the timeout interrupt |
| timeout_irq | output | 1 | Sticky receive idle timeout interrupt |

## Verification
The assertions assume that `bit_tick`, `byte_rx` and `irq_clear` are synchronous single-cycle pulses. They also assume that `thresh` is held stable while a count is running. The bench drives every input just after a falling edge and releases each pulse after one cycle. It changes `thresh` only between scenarios. It sends at most one bit tick every two cycles, which keeps the tick rate within what a baud generator would produce.

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer #(
  parameter int SYM_BITS = 11,
  parameter int THR_W    = 7,
  parameter int THR_MAX  = 126
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             byte_rx,
  input  logic             fifo_nonempty,
  input  logic [THR_W-1:0] thresh,
  input  logic             irq_clear,
  output logic             timeout_irq
);

  localparam int BW = $clog2(SYM_BITS);
  localparam logic [BW-1:0]    BIT_LAST = BW'(SYM_BITS - 1);
  localparam logic [THR_W-1:0] SYM_SAT  = {THR_W{1'b1}};
  localparam logic [THR_W-1:0] THR_CAP  = THR_W'(THR_MAX);

  logic [BW-1:0]    bit_cnt;
  logic [THR_W-1:0] sym_cnt;
  logic [THR_W-1:0] thr_eff;
  logic             armed;
  logic             fire;
  logic             sym_done;

  assign thr_eff  = (thresh > THR_CAP) ? THR_CAP : thresh;
  assign sym_done = bit_tick && (bit_cnt == BIT_LAST);
  assign fire     = armed && fifo_nonempty && !byte_rx &&
                    (thr_eff != '0) && (sym_cnt >= thr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sym_cnt <= '0;
    end else if (byte_rx || !fifo_nonempty) begin
      bit_cnt <= '0;
      sym_cnt <= '0;
    end else if (bit_tick) begin
      bit_cnt <= sym_done ? '0 : bit_cnt + 1'b1;
      if (sym_done && sym_cnt != SYM_SAT)
        sym_cnt <= sym_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (byte_rx) armed <= 1'b1;
    else if (fire)    armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timeout_irq <= 1'b0;
    else        timeout_irq <= fire || (timeout_irq && !irq_clear);
  end

  always_comb begin
    AST_BIT_RANGE: assert (!rst_n || bit_cnt < SYM_BITS); // R2
  end

  AST_BYTE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rx && !timeout_irq) |=> !timeout_irq); // R3

  AST_EMPTY_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_nonempty && !timeout_irq) |=> !timeout_irq); // R4

  AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0 && !timeout_irq) |=> !timeout_irq); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_irq && !irq_clear) |=> timeout_irq); // R7

  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !byte_rx && !timeout_irq) |=> !timeout_irq); // R8

endmodule

// File: tb/test_uart_rx_idle_timer.sv
module test_uart_rx_idle_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic byte_rx = 1'b0;
  logic fifo_nonempty = 1'b0;
  logic [6:0] thresh = 7'd0;
  logic irq_clear = 1'b0;
  logic timeout_irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_rx_idle_timer i_uart_rx_idle_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .byte_rx(byte_rx),
    .fifo_nonempty(fifo_nonempty), .thresh(thresh), .irq_clear(irq_clear),
    .timeout_irq(timeout_irq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: timeout_irq=%b expected %b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask

  task automatic rx_byte();
    @(negedge clk) begin byte_rx = 1'b1; fifo_nonempty = 1'b1; end
    @(negedge clk) byte_rx = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clear = 1'b1;
    @(negedge clk) irq_clear = 1'b0;
  endtask

  task automatic t_reset();
    check(timeout_irq, 1'b0, "R1 after reset");
    thresh = 7'd1;
    fifo_nonempty = 1'b1;
    ticks(30);
    check(timeout_irq, 1'b0, "R1 unarmed ticks");
  endtask

  task automatic t_basic();
    thresh = 7'd3;
    rx_byte();
    ticks(32);
    repeat (3) @(negedge clk);
    check(timeout_irq, 1'b0, "R2 one tick short");
    ticks(1);
    check(timeout_irq, 1'b0, "R2 at final tick edge");
    @(negedge clk);
    check(timeout_irq, 1'b1, "R2 one edge later");
    repeat (5) @(negedge clk);
    check(timeout_irq, 1'b1, "R7 sticky");
    clear_irq();
    check(timeout_irq, 1'b0, "R7 cleared");
  endtask

  task automatic t_rearm();
    ticks(40);
    check(timeout_irq, 1'b0, "R8 no refire without byte");
    rx_byte();
    ticks(33);
    @(negedge clk);
    check(timeout_irq, 1'b1, "R8 refire after byte");
    clear_irq();
  endtask

  task automatic t_restart();
    thresh = 7'd2;
    rx_byte();
    ticks(20);
    rx_byte();
    ticks(20);
    @(negedge clk);
    check(timeout_irq, 1'b0, "R3 count restarted");
    ticks(2);
    @(negedge clk);
    check(timeout_irq, 1'b1, "R3 fires 22 ticks after last byte");
    clear_irq();
  endtask

  task automatic t_empty();
    thresh = 7'd2;
    rx_byte();
    ticks(5);
    fifo_nonempty = 1'b0;
    ticks(30);
    check(timeout_irq, 1'b0, "R4 empty fifo no irq");
    fifo_nonempty = 1'b1;
    ticks(21);
    @(negedge clk);
    check(timeout_irq, 1'b0, "R4 recount from zero");
    ticks(1);
    @(negedge clk);
    check(timeout_irq, 1'b1, "R4 fires after 22 ticks");
    clear_irq();
  endtask

  task automatic t_zero();
    thresh = 7'd0;
    rx_byte();
    ticks(200);
    check(timeout_irq, 1'b0, "R5 zero threshold");
    fifo_nonempty = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_clamp();
    thresh = 7'd127;
    rx_byte();
    ticks(1385);
    @(negedge clk);
    check(timeout_irq, 1'b0, "R6 one tick before 1386");
    ticks(1);
    @(negedge clk);
    check(timeout_irq, 1'b1, "R6 clamped to 126");
    clear_irq();
    check(timeout_irq, 1'b0, "R7 clear after clamp");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rearm();
    t_restart();
    t_empty();
    t_zero();
    t_clamp();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: timeout_irq=%b expected run to finish", timeout_irq);
      summary();
    end
  end
endmodule